// File: doc/BRIEF.md
# Long-Mode Control Register Unit

This unit holds the mode-control state of a processor core: a 64-bit extended feature register reached through a model-specific-register style port, the protection and paging bits of the primary control word, the address-extension bit of a second control word, and the root translation-table base. It never accepts a direct write of the long-mode-active flag. Instead it derives that flag from the long-mode enable, address-extension and paging bits, and it refuses any write that would break the required order for entering or leaving long mode.

Each register write is checked against the current state and the privilege input. A legal write commits at the next clock edge. An illegal write changes nothing and raises a one-cycle fault pulse. The unit combines the stored state with the L bit of the current code segment and reports one of four operating modes. Decode logic upstream presents at most one useful access per cycle. When strobes collide, a fixed priority picks the single access that is processed.

Top module: `lm_mode_ctrl`

## Requirements
- R1: After synchronous reset every stored bit is 0, `op_mode` reads 0 (real), `fault` is 0, and a privileged read of the feature register returns 0.
- R2: The feature register answers at index 0xC0000080. Its image has syscall enable at bit 0, long-mode enable at bit 8, long-mode active at bit 10 and no-execute enable at bit 11. Bits 0, 8 and 11 are writable. Bit 10 ignores written data. A write with a 1 in any other bit position faults and changes nothing. An access at any other index returns 0, changes nothing and does not fault.
- R3: While `ring0` is 0, every access (feature read or write, control word, extension word, root base) faults and changes nothing, and `msr_rdata` is 0.
- R4: In the control word, bit 0 enables protection and bit 31 enables paging, and the other bits are ignored. A write whose protection bit is 0 faults if its paging bit is 1 or if paging is currently on. Paging can therefore only be set with protection, and must be cleared before protection is cleared.
- R5: Bit 5 of the extension word enables address extensions, and the other bits are ignored. A write that clears it while long mode is active faults.
- R6: A feature-register write that changes the long-mode enable bit while paging is on faults and leaves the register unchanged.
- R7: `lm_active` becomes 1 only when a control write turns paging from 0 to 1 while long-mode enable and address extensions are both set. It returns to 0 on the write that clears paging. Turning paging on while long-mode enable is set and address extensions are clear faults.
- R8: `op_mode` is 0 for real (protection off, long mode inactive), 1 for protected (protection on, long mode inactive), 2 for 64-bit (long mode active, `cs_long`=1) and 3 for compatibility (long mode active, `cs_long`=0). It follows `cs_long` in the same cycle.
- R9: `fault` is 1 for exactly the cycle after an illegal access and is 0 after every legal access or idle cycle.
- R10: When several strobes are high together, only one access is processed, in this priority order: feature access (read or write), then control word, then extension word, then root base. The lower ones are dropped.
- R11: A legal root-base write stores the 64-bit value with bits 11:0 forced to 0, and `root_base` shows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring0 | input | 1 | 1 when the requester runs at the most privileged ring |
| msr_wr_en | input | 1 | Feature-port write strobe |
| msr_rd_en | input | 1 | Feature-port read strobe |
| msr_idx | input | 32 | Feature-port register index |
| msr_wdata | input | 64 | Feature-port write data |
| msr_rdata | output | 64 | Feature-port read data, combinational |
| ctl_wr_en | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control-word write data |
| ext_wr_en | input | 1 | Extension-word write strobe |
| ext_wdata | input | 32 | Extension-word write data |
| root_wr_en | input | 1 | Root-base write strobe |
| root_wdata | input | 64 | Root-base write data |
| cs_long | input | 1 | L bit of the current code segment |
| op_mode | output | 2 | Operating mode code |
| lm_active | output | 1 | Derived long-mode-active flag |
| prot_on | output | 1 | Protection enable state |
| paging_on | output | 1 | Paging enable state |
| addr_ext_on | output | 1 | Address-extension enable state |
| root_base | output | 64 | Stored root table base |
| fault | output | 1 | One-cycle illegal-access pulse |

## Verification
The assertions assume nothing about the inputs except that reset is applied before the first checked cycle. They do assume that the stored bits can only move through legal commits. Under that assumption, paging implies protection, an active long mode implies its three enabling bits, and the enable bit cannot move while paging is held. The stimulus drives strobes, privilege and data freely, including colliding strobes, reserved bits, foreign indexes and unprivileged accesses. Writes are biased toward the enable bits so that random runs regularly reach and leave long mode. A directed walk covers the full entry and exit order and each refused transition.

// File: rtl/lmc_pkg.sv
// Package: shared mode codes and bit positions for the long-mode control unit.
// Assumes: control words are at least 32 bits wide, feature image at least 12 bits.
package lmc_pkg;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_PROT   = 2'd1,
        MODE_LONG64 = 2'd2,
        MODE_COMPAT = 2'd3
    } op_mode_t;

    // Feature register bit positions
    localparam int FB_SYSCALL = 0;
    localparam int FB_LME     = 8;
    localparam int FB_LMA     = 10;
    localparam int FB_NXE     = 11;

    // Control word bit positions
    localparam int CB_PROT    = 0;
    localparam int CB_PAGING  = 31;

    // Extension word bit position
    localparam int XB_ADDR_EXT = 5;

endpackage

// File: rtl/lmc_feat_reg.sv
// Module: feature register behind the index/data port.
// Holds syscall, long-mode enable and no-execute bits; shows the derived
// long-mode-active flag in its read image. Checks privilege, reserved bits
// and the rule that long-mode enable is frozen while paging is on.
// Assumes: sel is the arbitrated access grant; rd/wr are the raw strobes.
module lmc_feat_reg
    import lmc_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter int                IDX_W    = 32,
    parameter logic [IDX_W-1:0]  FEAT_IDX = 32'hC000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic              priv,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              paging_on,
    input  logic              lm_active,
    output logic [DATA_W-1:0] rdata,
    output logic              sce,
    output logic              lme,
    output logic              nxe,
    output logic              fault_now
);

    localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
    localparam logic [DATA_W-1:0] KNOWN_MASK = (ONE << FB_SYSCALL) | (ONE << FB_LME)
                                             | (ONE << FB_LMA)     | (ONE << FB_NXE);

    logic sce_q, lme_q, nxe_q;
    logic hit, rsvd_set, lme_flip, wr_bad, commit;

    // Legality of the presented access
    always_comb begin
        hit       = (idx == FEAT_IDX);
        rsvd_set  = |(wdata & ~KNOWN_MASK);
        lme_flip  = (wdata[FB_LME] != lme_q);
        wr_bad    = wr && hit && (rsvd_set || (lme_flip && paging_on));
        fault_now = sel && (!priv || wr_bad);
        commit    = sel && wr && priv && hit && !wr_bad;
    end

    // Store the writable bits on a legal write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sce_q <= 1'b0;
            lme_q <= 1'b0;
            nxe_q <= 1'b0;
        end else if (commit) begin
            sce_q <= wdata[FB_SYSCALL];
            lme_q <= wdata[FB_LME];
            nxe_q <= wdata[FB_NXE];
        end
    end

    // Read image, zero unless a privileged read hits the index
    always_comb begin
        rdata = '0;
        if (rd && priv && hit) begin
            rdata[FB_SYSCALL] = sce_q;
            rdata[FB_LME]     = lme_q;
            rdata[FB_LMA]     = lm_active;
            rdata[FB_NXE]     = nxe_q;
        end
    end

    assign sce = sce_q;
    assign lme = lme_q;
    assign nxe = nxe_q;

endmodule

// File: rtl/lmc_ctl_regs.sv
// Module: protection/paging word, address-extension word, root base, and
// the derived long-mode-active flag.
// Enforces entry order (enable, extensions, paging with protection) and
// exit order (paging off before protection off).
// Assumes: at most one of the three select inputs is high (arbitrated above).
module lmc_ctl_regs
    import lmc_pkg::*;
#(
    parameter int CTL_W      = 32,
    parameter int ROOT_W     = 64,
    parameter int ROOT_ALIGN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv,
    input  logic              lme,
    input  logic              ctl_sel,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ext_sel,
    input  logic [CTL_W-1:0]  ext_wdata,
    input  logic              root_sel,
    input  logic [ROOT_W-1:0] root_wdata,
    output logic              prot_on,
    output logic              paging_on,
    output logic              addr_ext_on,
    output logic              lm_active,
    output logic [ROOT_W-1:0] root_q,
    output logic              fault_now
);

    localparam logic [ROOT_W-1:0] ONE      = ROOT_W'(1);
    localparam logic [ROOT_W-1:0] LOW_MASK = (ONE << ROOT_ALIGN) - ONE;

    logic pe_q, pg_q, pae_q, lma_q;
    logic n_pe, n_pg, n_pae;
    logic ctl_bad, ext_bad, root_bad;
    logic lma_next;
    logic unused_word_bits;

    // Decode the relevant bits of each write word
    always_comb begin
        n_pe  = ctl_wdata[CB_PROT];
        n_pg  = ctl_wdata[CB_PAGING];
        n_pae = ext_wdata[XB_ADDR_EXT];
    end

    assign unused_word_bits = ^{ctl_wdata, ext_wdata};

    // Legality of each word write against the current state
    always_comb begin
        ctl_bad  = !priv
                || (!n_pe && (n_pg || pg_q))
                || (n_pg && !pg_q && lme && !pae_q);
        ext_bad  = !priv || (!n_pae && lma_q);
        root_bad = !priv;
        fault_now = (ctl_sel && ctl_bad) || (ext_sel && ext_bad) || (root_sel && root_bad);
    end

    // Long mode turns on only with a paging rise under enable+extensions
    always_comb begin
        if (n_pg) begin
            lma_next = lma_q || (!pg_q && lme && pae_q);
        end else begin
            lma_next = 1'b0;
        end
    end

    // Protection, paging and the derived active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe_q  <= 1'b0;
            pg_q  <= 1'b0;
            lma_q <= 1'b0;
        end else if (ctl_sel && !ctl_bad) begin
            pe_q  <= n_pe;
            pg_q  <= n_pg;
            lma_q <= lma_next;
        end
    end

    // Address-extension enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pae_q <= 1'b0;
        end else if (ext_sel && !ext_bad) begin
            pae_q <= n_pae;
        end
    end

    // Root table base, low bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
        end else if (root_sel && !root_bad) begin
            root_q <= root_wdata & ~LOW_MASK;
        end
    end

    assign prot_on     = pe_q;
    assign paging_on   = pg_q;
    assign addr_ext_on = pae_q;
    assign lm_active   = lma_q;

endmodule

// File: rtl/lmc_mode_dec.sv
// Module: operating mode decoder.
// Maps protection, long-mode-active and the code segment L bit to a mode code.
// Assumes: inputs are stable register outputs plus a live segment bit.
module lmc_mode_dec
    import lmc_pkg::*;
(
    input  logic     prot_on,
    input  logic     lm_active,
    input  logic     cs_long,
    output op_mode_t mode
);

    // Pick the mode; long mode overrides the plain protection view
    always_comb begin
        if (lm_active) begin
            mode = cs_long ? MODE_LONG64 : MODE_COMPAT;
        end else if (prot_on) begin
            mode = MODE_PROT;
        end else begin
            mode = MODE_REAL;
        end
    end

endmodule

// File: rtl/lm_mode_ctrl.sv
// Module: long-mode control register unit (top).
// Arbitrates the four access strobes, hosts the feature register, the
// control words and the mode decoder, and registers a one-cycle fault pulse.
// Assumes: synchronous active-low reset; strobes are single-cycle requests.
module lm_mode_ctrl
    import lmc_pkg::*;
#(
    parameter int               DATA_W     = 64,
    parameter int               IDX_W      = 32,
    parameter int               CTL_W      = 32,
    parameter int               ROOT_ALIGN = 12,
    parameter logic [IDX_W-1:0] FEAT_IDX   = 32'hC000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring0,
    input  logic              msr_wr_en,
    input  logic              msr_rd_en,
    input  logic [IDX_W-1:0]  msr_idx,
    input  logic [DATA_W-1:0] msr_wdata,
    output logic [DATA_W-1:0] msr_rdata,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ext_wr_en,
    input  logic [CTL_W-1:0]  ext_wdata,
    input  logic              root_wr_en,
    input  logic [DATA_W-1:0] root_wdata,
    input  logic              cs_long,
    output logic [1:0]        op_mode,
    output logic              lm_active,
    output logic              prot_on,
    output logic              paging_on,
    output logic              addr_ext_on,
    output logic [DATA_W-1:0] root_base,
    output logic              fault
);

    logic     msr_sel, ctl_sel, ext_sel, root_sel;
    logic     feat_fault, word_fault, fault_q;
    logic     sce_q, lme_q, nxe_q;
    logic     unused_feat_bits;
    op_mode_t mode_w;

    // Fixed priority: feature port, control, extension, root
    always_comb begin
        msr_sel  = msr_wr_en || msr_rd_en;
        ctl_sel  = ctl_wr_en && !msr_sel;
        ext_sel  = ext_wr_en && !msr_sel && !ctl_wr_en;
        root_sel = root_wr_en && !msr_sel && !ctl_wr_en && !ext_wr_en;
    end

    lmc_feat_reg #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .FEAT_IDX (FEAT_IDX)
    ) u_feat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (msr_sel),
        .wr        (msr_wr_en),
        .rd        (msr_rd_en),
        .priv      (ring0),
        .idx       (msr_idx),
        .wdata     (msr_wdata),
        .paging_on (paging_on),
        .lm_active (lm_active),
        .rdata     (msr_rdata),
        .sce       (sce_q),
        .lme       (lme_q),
        .nxe       (nxe_q),
        .fault_now (feat_fault)
    );

    assign unused_feat_bits = sce_q ^ nxe_q;

    lmc_ctl_regs #(
        .CTL_W      (CTL_W),
        .ROOT_W     (DATA_W),
        .ROOT_ALIGN (ROOT_ALIGN)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv        (ring0),
        .lme         (lme_q),
        .ctl_sel     (ctl_sel),
        .ctl_wdata   (ctl_wdata),
        .ext_sel     (ext_sel),
        .ext_wdata   (ext_wdata),
        .root_sel    (root_sel),
        .root_wdata  (root_wdata),
        .prot_on     (prot_on),
        .paging_on   (paging_on),
        .addr_ext_on (addr_ext_on),
        .lm_active   (lm_active),
        .root_q      (root_base),
        .fault_now   (word_fault)
    );

    lmc_mode_dec u_mode (
        .prot_on   (prot_on),
        .lm_active (lm_active),
        .cs_long   (cs_long),
        .mode      (mode_w)
    );

    // One-cycle fault pulse after an illegal access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= feat_fault || word_fault;
        end
    end

    assign op_mode = mode_w;
    assign fault   = fault_q;

endmodule

// File: rtl/lmc_checker.sv
// Module: assertion checker for the long-mode control unit, bound to the top.
// Assumes: reset is asserted before the first checked edge.
module lmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ring0,
    input logic       msr_wr_en,
    input logic       msr_rd_en,
    input logic       ctl_wr_en,
    input logic       ext_wr_en,
    input logic       root_wr_en,
    input logic       cs_long,
    input logic [1:0] op_mode,
    input logic       lm_active,
    input logic       prot_on,
    input logic       paging_on,
    input logic       addr_ext_on,
    input logic       fault,
    input logic       lme
);

    AST_PAGING_NEEDS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        paging_on |-> prot_on); // R4

    AST_ACTIVE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        lm_active |-> (paging_on && addr_ext_on && lme)); // R7

    AST_ACTIVE_ON_PAGING_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lm_active) |-> $rose(paging_on)); // R7

    AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(paging_on) |-> $stable(lme)); // R6

    AST_EXT_HELD_IN_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lm_active) && lm_active) |-> $stable(addr_ext_on)); // R5

    AST_UNPRIV_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_wr_en && !ring0) |=> fault); // R3

    AST_MODE_64: assert property (@(posedge clk) disable iff (!rst_n)
        (lm_active && cs_long) |-> (op_mode == 2'd2)); // R8

    AST_MODE_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!lm_active && !prot_on) |-> (op_mode == 2'd0)); // R8

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(msr_wr_en || msr_rd_en || ctl_wr_en || ext_wr_en || root_wr_en)); // R9

endmodule

bind lm_mode_ctrl lmc_checker u_lmc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring0       (ring0),
    .msr_wr_en   (msr_wr_en),
    .msr_rd_en   (msr_rd_en),
    .ctl_wr_en   (ctl_wr_en),
    .ext_wr_en   (ext_wr_en),
    .root_wr_en  (root_wr_en),
    .cs_long     (cs_long),
    .op_mode     (op_mode),
    .lm_active   (lm_active),
    .prot_on     (prot_on),
    .paging_on   (paging_on),
    .addr_ext_on (addr_ext_on),
    .fault       (fault),
    .lme         (lme_q)
);

// File: tb/test_lm_mode_ctrl.sv
// Bench: directed walk through entry/exit order plus seeded random accesses,
// checked against a bench-side reference model built from the requirements.
module test_lm_mode_ctrl;

    localparam time         PERIOD = 20ns;
    localparam logic [31:0] FIDX   = 32'hC000_0080;
    localparam logic [63:0] FMASK  = 64'h0000_0000_0000_0D01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring0, msr_wr_en, msr_rd_en, ctl_wr_en, ext_wr_en, root_wr_en, cs_long;
    logic [31:0] msr_idx, ctl_wdata, ext_wdata;
    logic [63:0] msr_wdata, root_wdata, msr_rdata, root_base;
    logic [1:0]  op_mode;
    logic        lm_active, prot_on, paging_on, addr_ext_on, fault;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state
    bit m_sce, m_lme, m_nxe, m_pe, m_pg, m_pae, m_lma, m_fault;
    logic [63:0] m_root;

    always #(PERIOD/2) clk = ~clk;

    lm_mode_ctrl i_lm_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ring0(ring0),
        .msr_wr_en(msr_wr_en), .msr_rd_en(msr_rd_en), .msr_idx(msr_idx),
        .msr_wdata(msr_wdata), .msr_rdata(msr_rdata),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
        .ext_wr_en(ext_wr_en), .ext_wdata(ext_wdata),
        .root_wr_en(root_wr_en), .root_wdata(root_wdata),
        .cs_long(cs_long), .op_mode(op_mode), .lm_active(lm_active),
        .prot_on(prot_on), .paging_on(paging_on), .addr_ext_on(addr_ext_on),
        .root_base(root_base), .fault(fault)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode();
        if (m_lma) return cs_long ? 2'd2 : 2'd3;
        return m_pe ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [63:0] exp_rdata();
        logic [63:0] v = '0;
        if (msr_rd_en && ring0 && msr_idx == FIDX) begin
            v[0] = m_sce; v[8] = m_lme; v[10] = m_lma; v[11] = m_nxe;
        end
        return v;
    endfunction

    // Reference model of one access cycle, priority feature > ctl > ext > root
    task automatic model_step();
        bit f = 0;
        if (msr_wr_en || msr_rd_en) begin
            if (!ring0) f = 1;
            else if (msr_wr_en && msr_idx == FIDX) begin
                if ((|(msr_wdata & ~FMASK)) || ((msr_wdata[8] != m_lme) && m_pg)) f = 1;
                else begin
                    m_sce = msr_wdata[0]; m_lme = msr_wdata[8]; m_nxe = msr_wdata[11];
                end
            end
        end else if (ctl_wr_en) begin
            bit npe = ctl_wdata[0];
            bit npg = ctl_wdata[31];
            if (!ring0 || (!npe && (npg || m_pg)) || (npg && !m_pg && m_lme && !m_pae)) f = 1;
            else begin
                if (!npg) m_lma = 0;
                else if (!m_pg && m_lme && m_pae) m_lma = 1;
                m_pe = npe; m_pg = npg;
            end
        end else if (ext_wr_en) begin
            if (!ring0 || (!ext_wdata[5] && m_lma)) f = 1;
            else m_pae = ext_wdata[5];
        end else if (root_wr_en) begin
            if (!ring0) f = 1;
            else m_root = {root_wdata[63:12], 12'h000};
        end
        m_fault = f;
    endtask

    task automatic clear_in();
        ring0 = 1; msr_wr_en = 0; msr_rd_en = 0; ctl_wr_en = 0; ext_wr_en = 0; root_wr_en = 0;
    endtask

    task automatic check_state();
        chk("R9 fault", {63'd0, fault}, {63'd0, m_fault});
        chk("R8 mode", {62'd0, op_mode}, {62'd0, exp_mode()});
        chk("R7 lm_active", {63'd0, lm_active}, {63'd0, m_lma});
        chk("R4 prot", {63'd0, prot_on}, {63'd0, m_pe});
        chk("R4 paging", {63'd0, paging_on}, {63'd0, m_pg});
        chk("R5 addr_ext", {63'd0, addr_ext_on}, {63'd0, m_pae});
        chk("R11 root", root_base, m_root);
    endtask

    // Entered at a falling edge with inputs set; checks read data, then state
    task automatic step();
        #2;
        chk("R2 rdata", msr_rdata, exp_rdata());
        model_step();
        @(negedge clk);
        clear_in();
        check_state();
    endtask

    task automatic msr_write(input logic [31:0] idx, input logic [63:0] d, input bit pr);
        ring0 = pr; msr_wr_en = 1; msr_idx = idx; msr_wdata = d; step();
    endtask
    task automatic msr_read(input bit pr);
        ring0 = pr; msr_rd_en = 1; msr_idx = FIDX; #2;
        chk("R2 read image", msr_rdata, exp_rdata());
        step();
    endtask
    task automatic ctl_write(input logic [31:0] d);
        ctl_wr_en = 1; ctl_wdata = d; step();
    endtask
    task automatic ext_write(input logic [31:0] d);
        ext_wr_en = 1; ext_wdata = d; step();
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7151));
        clear_in();
        msr_idx = FIDX; msr_wdata = '0; ctl_wdata = '0; ext_wdata = '0; root_wdata = '0; cs_long = 0;
        m_sce = 0; m_lme = 0; m_nxe = 0; m_pe = 0; m_pg = 0; m_pae = 0; m_lma = 0; m_fault = 0; m_root = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 mode after reset", {62'd0, op_mode}, 64'd0);
        chk("R1 fault after reset", {63'd0, fault}, 64'd0);
        chk("R1 root after reset", root_base, 64'd0);
        msr_rd_en = 1; #2;
        chk("R1 feature image after reset", msr_rdata, 64'd0);
        step();

        // Entry order: enable, extensions, root, paging with protection
        msr_write(FIDX, 64'h100, 1);
        msr_rd_en = 1; #2; chk("R2 enable readback", msr_rdata, 64'h100); step();
        ext_write(32'h20);
        chk("R5 extensions on", {63'd0, addr_ext_on}, 64'd1);
        root_wr_en = 1; root_wdata = 64'h1234_5678_9ABC_DEF0; step();
        chk("R11 low bits dropped", root_base, 64'h1234_5678_9ABC_D000);
        cs_long = 1;
        ctl_write(32'h8000_0001);
        chk("R7 active after paging rise", {63'd0, lm_active}, 64'd1);
        chk("R8 64-bit mode", {62'd0, op_mode}, 64'd2);
        cs_long = 0; #2;
        chk("R8 compatibility mode", {62'd0, op_mode}, 64'd3);
        msr_rd_en = 1; #2; chk("R2 active bit in image", msr_rdata, 64'h500); step();

        // Refused transitions in long mode
        msr_write(FIDX, 64'h0, 1);
        chk("R6 enable change with paging faults", {63'd0, fault}, 64'd1);
        msr_rd_en = 1; #2; chk("R6 image unchanged", msr_rdata, 64'h500); step();
        chk("R9 fault drops after one cycle", {63'd0, fault}, 64'd0);
        ext_write(32'h0);
        chk("R5 clearing extensions faults", {63'd0, fault}, 64'd1);
        ctl_write(32'h0);
        chk("R4 clearing both faults", {63'd0, fault}, 64'd1);
        chk("R4 paging kept", {63'd0, paging_on}, 64'd1);

        // Exit order
        ctl_write(32'h1);
        chk("R7 active cleared with paging", {63'd0, lm_active}, 64'd0);
        chk("R8 protected mode", {62'd0, op_mode}, 64'd1);
        ctl_write(32'h0);
        chk("R8 real mode", {62'd0, op_mode}, 64'd0);

        // Privilege, reserved bits, foreign index
        msr_write(FIDX, 64'h900, 0);
        chk("R3 unprivileged write faults", {63'd0, fault}, 64'd1);
        ring0 = 0; msr_rd_en = 1; #2; chk("R3 unprivileged read is zero", msr_rdata, 64'd0); step();
        chk("R3 unprivileged read faults", {63'd0, fault}, 64'd1);
        msr_write(FIDX, 64'h102, 1);
        chk("R2 reserved bit faults", {63'd0, fault}, 64'd1);
        msr_write(FIDX, 64'h400, 1);
        chk("R2 active bit write is legal", {63'd0, fault}, 64'd0);
        msr_rd_en = 1; #2; chk("R2 active bit ignores data", msr_rdata, 64'h0); step();
        msr_write(32'h0000_0010, 64'h1, 1);
        chk("R2 foreign index no fault", {63'd0, fault}, 64'd0);

        // Order faults outside long mode
        ctl_write(32'h8000_0000);
        chk("R4 paging without protection faults", {63'd0, fault}, 64'd1);
        ext_write(32'h0);
        msr_write(FIDX, 64'h100, 1);
        ctl_write(32'h8000_0001);
        chk("R7 paging with enable but no extensions faults", {63'd0, fault}, 64'd1);

        // Priority between colliding strobes
        ctl_wr_en = 1; ctl_wdata = 32'h1; ext_wr_en = 1; ext_wdata = 32'h20; step();
        chk("R10 control wins over extension", {63'd0, addr_ext_on}, 64'd0);
        msr_rd_en = 1; ctl_wr_en = 1; ctl_wdata = 32'h0; step();
        chk("R10 feature access wins over control", {63'd0, prot_on}, 64'd1);
        ctl_write(32'h0);

        // Seeded random accesses
        for (int n = 0; n < 3000; n++) begin
            int k;
            clear_in();
            ring0 = ($urandom % 10) != 0;
            cs_long = $urandom % 2;
            msr_idx = ($urandom % 8 == 0) ? $urandom : FIDX;
            msr_wdata = '0;
            msr_wdata[0] = $urandom % 2;
            msr_wdata[8] = ($urandom % 10) < 6;
            msr_wdata[10] = $urandom % 2;
            msr_wdata[11] = $urandom % 2;
            if ($urandom % 10 == 0) msr_wdata = msr_wdata | (64'd1 << ($urandom % 64));
            ctl_wdata = $urandom;
            ctl_wdata[0] = ($urandom % 4) != 0;
            ctl_wdata[31] = $urandom % 2;
            ext_wdata = $urandom;
            ext_wdata[5] = ($urandom % 10) < 7;
            root_wdata = {$urandom, $urandom};
            k = $urandom % 5;
            case (k)
                0: msr_wr_en = 1;
                1: msr_rd_en = 1;
                2: ctl_wr_en = 1;
                3: ext_wr_en = 1;
                default: root_wr_en = 1;
            endcase
            if ($urandom % 8 == 0) begin
                case ($urandom % 4)
                    0: msr_rd_en = 1;
                    1: ctl_wr_en = 1;
                    2: ext_wr_en = 1;
                    default: root_wr_en = 1;
                endcase
            end
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule